// File: doc/BRIEF.md
# Tagged Many-to-One Merge Queue

This block collects words from several independent producers and hands them to a single consumer as one stream. Every producer port writes into a small queue of its own, so a slow consumer does not block a producer until that producer's queue is full. Each word leaving the block carries, in its upper bits, the index of the port it entered on. The consumer can therefore tell the sources apart without any extra sideband.

A round-robin arbiter chooses among the queues that hold data. Once a word is offered, the offer stays fixed until the consumer acknowledges it. The acknowledge removes that word from its queue and moves the priority to the next port. A port that keeps its queue non-empty cannot starve the others.

Top module: `tag_merge`

## Requirements
- R1: Each of the NUM_SRC ports has its own queue of DEPTH words (default 2). A word is stored when that port's `src_valid` and `src_ready` are both high at a clock edge. Port s takes its data from bits [s*DATA_W +: DATA_W] of `src_data`, and each queue delivers its words in arrival order.
- R2: `src_ready[s]` is low exactly when queue s holds DEPTH words. Otherwise it is high.
- R3: `out_valid` is high exactly when at least one queue holds a word. A word stored at an edge is first visible after that edge.
- R4: `out_word` is {ID, data}. The ID is the port index in the upper ID_W bits, where ID_W = ceil(log2 NUM_SRC), with a minimum of 1. The data is the head word of that port's queue, in the lower DATA_W bits.
- R5: While `out_valid` is high and `out_ack` is low, `out_valid` and `out_word` keep their values on the next cycle.
- R6: An edge with `out_valid` and `out_ack` both high removes exactly one word, from the offered port's queue only. `out_ack` has no effect while `out_valid` is low.
- R7: The offered port is the first non-empty queue found when searching upward from a priority pointer, wrapping past NUM_SRC-1 to 0. After an acknowledge, the pointer moves to the port that follows the one that was served.
- R8: A write offered while `src_ready` is low is dropped and never appears on the output.
- R9: While `rst_n` is low at a clock edge, all queues empty and the priority pointer returns to port 0. After that reset, `out_valid` is low and all `src_ready` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_valid | input | NUM_SRC | Per-port write request |
| src_data | input | NUM_SRC*DATA_W | Per-port write data, port s at [s*DATA_W +: DATA_W] |
| src_ready | output | NUM_SRC | Per-port queue has space |
| out_valid | output | 1 | A tagged word is offered |
| out_word | output | ID_W+DATA_W | {source ID, data} |
| out_ack | input | 1 | Consumer takes the offered word |

## Verification
The embedded properties check on every cycle that the offer holds steady until it is acknowledged, and that the offered port really holds data. They also check that no queue is read while empty or filled beyond its depth, and that at most one queue is drained per edge. The bench alone can show how the grants are ordered: the exact rotation of the round-robin pointer, per-port arrival order, and that a write refused by a full queue never reaches the output. It also covers that a reset in the middle of traffic discards queued words.

// File: rtl/tmerge_pkg.sv
// Shared helpers for the tagged merge queue.
// Assumes: widths are derived at elaboration time only.
package tmerge_pkg;
    // Width of a source index; never below one bit.
    function automatic int id_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/src_queue.sv
// Per-port FIFO of DEPTH words with registered storage.
// Assumes: pop is only raised while the queue is non-empty; ready is
// derived from occupancy only, so a push never lands on a full queue.
module src_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              nonempty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              do_push;

    // Space and occupancy flags from the count.
    always_comb begin
        push_ready = (count != CW'(DEPTH));
        nonempty   = (count != '0);
        do_push    = push_valid && push_ready;
        head       = mem[rd_ptr];
    end

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);
endmodule

// File: rtl/rr_pick.sv
// Round-robin selector with offer hold.
// Picks the first requesting port at or above the pointer, holds that
// choice until ack, then moves the pointer past the served port.
// Assumes: a granted request stays high until acknowledged.
module rr_pick #(
    parameter int N    = 4,
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic            ack,
    output logic            valid,
    output logic [ID_W-1:0] grant
);
    logic [ID_W-1:0] ptr, held, pick;
    logic            busy, any;

    // Rotating search, lowest distance from the pointer wins.
    always_comb begin
        int idx;
        pick = '0;
        any  = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (req[idx]) begin
                pick = ID_W'(idx);
                any  = 1'b1;
            end
        end
        grant = busy ? held : pick;
        valid = busy || any;
    end

    // Pointer advance on ack, hold latch while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            held <= '0;
            busy <= 1'b0;
        end else if (valid && ack) begin
            busy <= 1'b0;
            ptr  <= (grant == ID_W'(N - 1)) ? '0 : grant + 1'b1;
        end else if (valid) begin
            busy <= 1'b1;
            held <= grant;
        end
    end

    // R5
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ack |=> valid && (grant == $past(grant)));

    // R3
    grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> req[grant]);
endmodule

// File: rtl/tag_merge.sv
// Tagged many-to-one merge: NUM_SRC queued inputs, one ID-tagged output
// with valid/ack handshake and round-robin fairness.
// Assumes: the consumer samples out_word while out_valid is high.
module tag_merge
    import tmerge_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 2,
    localparam int ID_W   = id_width(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_valid,
    input  logic [NUM_SRC*DATA_W-1:0] src_data,
    output logic [NUM_SRC-1:0]        src_ready,
    output logic                      out_valid,
    output logic [ID_W+DATA_W-1:0]    out_word,
    input  logic                      out_ack
);
    logic [DATA_W-1:0]  heads [NUM_SRC];
    logic [NUM_SRC-1:0] nonempty;
    logic [NUM_SRC-1:0] pop_vec;
    logic [ID_W-1:0]    grant;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_q
        // Dequeue only the offered port on a completed handshake.
        assign pop_vec[s] = out_valid && out_ack && (grant == ID_W'(s));

        src_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (src_valid[s]),
            .push_data  (src_data[s*DATA_W +: DATA_W]),
            .push_ready (src_ready[s]),
            .pop        (pop_vec[s]),
            .head       (heads[s]),
            .nonempty   (nonempty[s])
        );
    end

    rr_pick #(.N(NUM_SRC), .ID_W(ID_W)) i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (nonempty),
        .ack   (out_ack),
        .valid (out_valid),
        .grant (grant)
    );

    // Tag the granted head with its port index.
    always_comb begin
        out_word = {grant, heads[grant]};
    end

    // R5
    offer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ack |=> out_valid && $stable(out_word));

    // R6
    pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_vec));
endmodule

// File: tb/test_tag_merge.sv
`timescale 1ns/1ps
module test_tag_merge;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_valid = '0;
    logic [N*DW-1:0] src_data = '0;
    logic [N-1:0]  src_ready;
    logic          out_valid;
    logic [IW+DW-1:0] out_word;
    logic          out_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tag_merge #(.NUM_SRC(N), .DATA_W(DW), .DEPTH(2)) i_tag_merge (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .out_valid(out_valid), .out_word(out_word),
        .out_ack(out_ack)
    );

    // Row: push[4] base[8] ack[1] | exp_ov[1] exp_id[2] exp_data[8] exp_rdy[4]
    // Expected fields describe outputs before the row's inputs are applied.
    localparam int NROW = 12;
    localparam logic [27:0] TBL [NROW] = '{
        {4'b1111, 8'hA0, 1'b0, 1'b0, 2'd0, 8'h00, 4'b1111}, // idle after reset
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd0, 8'hA0, 4'b1111}, // R1 one word per port
        {4'b0000, 8'h00, 1'b0, 1'b1, 2'd1, 8'hA1, 4'b1111}, // R7 pointer moved to 1
        {4'b0001, 8'hB0, 1'b1, 1'b1, 2'd1, 8'hA1, 4'b1111}, // R5 held offer
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd2, 8'hA2, 4'b1111}, // R7 skip back to 0 not yet
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd3, 8'hA3, 4'b1111},
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd0, 8'hB0, 4'b1111}, // R7 wrap
        {4'b1000, 8'hC0, 1'b0, 1'b0, 2'd0, 8'h00, 4'b1111}, // R6 drained
        {4'b1000, 8'hD0, 1'b0, 1'b1, 2'd3, 8'hC3, 4'b1111},
        {4'b1000, 8'hE0, 1'b1, 1'b1, 2'd3, 8'hC3, 4'b0111}, // R2 full, R8 E3 dropped
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd3, 8'hD3, 4'b1111}, // R1 order kept
        {4'b0000, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 4'b1111}  // R8 nothing more
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] mask, input logic [7:0] base,
                         input logic ack);
        src_valid = mask;
        for (int s = 0; s < N; s++) src_data[s*DW +: DW] = base + 8'(s);
        out_ack = ack;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive('0, 8'h00, 1'b0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [10:0] prev;
        do_reset();
        // R9 reset state
        check(out_valid == 1'b0, "R9 valid", 32'(out_valid), 0);
        check(src_ready == 4'b1111, "R9 ready", 32'(src_ready), 32'hF);

        // Table walk
        for (int r = 0; r < NROW; r++) begin
            logic [27:0] v;
            v = TBL[r];
            check(out_valid == v[14], "R3 valid", 32'(out_valid), 32'(v[14]));
            check(src_ready == v[3:0], "R2 ready", 32'(src_ready), 32'(v[3:0]));
            if (v[14])
                check(out_word == v[13:4], "R1/R4/R6/R7 word",
                      32'(out_word), 32'(v[13:4]));
            drive(v[27:24], v[23:16], v[15]);
            @(negedge clk);
        end
        drive('0, 8'h00, 1'b0);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 dropped write", 32'(out_valid), 0);

        // R6: ack with nothing offered has no effect
        drive(4'b0000, 8'h00, 1'b1);
        @(negedge clk);
        drive(4'b0100, 8'h70, 1'b0);
        @(negedge clk);
        check(out_valid && out_word == {2'd2, 8'h72}, "R6 idle ack",
              32'(out_word), 32'({2'd2, 8'h72}));

        // R5: hold several cycles
        prev = out_word;
        drive(4'b1011, 8'h30, 1'b0);
        @(negedge clk);
        @(negedge clk);
        drive('0, 8'h00, 1'b0);
        @(negedge clk);
        check(out_valid && out_word == prev, "R5 stable",
              32'(out_word), 32'(prev));

        // R9: reset mid-traffic discards queued words
        do_reset();
        check(out_valid == 1'b0, "R9 flush", 32'(out_valid), 0);
        check(src_ready == 4'b1111, "R9 flush ready", 32'(src_ready), 32'hF);

        // R7: saturated fairness, rotation 0,1,2,3,...
        drive(4'b1111, 8'h50, 1'b0);
        @(negedge clk);
        drive(4'b1111, 8'h50, 1'b1);
        for (int g = 0; g < 12; g++) begin
            check(out_valid && out_word[DW +: IW] == IW'(g % N), "R7 rotation",
                  32'(out_word[DW +: IW]), 32'(g % N));
            @(negedge clk);
        end
        drive('0, 8'h00, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule